// File: doc/BRIEF.md
# Buffered Serial Port with Fractional Baud and Hardware Flow Control

This block is an asynchronous serial transmitter and receiver for 8-bit characters with one start bit, no parity and one stop bit. Each direction has its own 16-entry byte queue. A small register port lets a host do four things: push bytes for transmission, pop received bytes, program the baud rate, and select the receive threshold and flow-control options. The receive threshold drives a data-available interrupt. When automatic request-to-send is enabled, the same threshold also drives the RTS pin. When automatic clear-to-send is enabled, the CTS pin gates the start of each transmitted character.

The baud generator produces a 16x oversampling tick. The tick period is an integer divisor of the reference clock. A fractional accumulator lengthens some tick periods by one reference cycle, which gives fine rate steps from any reference clock. The transmitter and the receiver are enumerated state machines. Each has the states IDLE, START, DATA and STOP, and each moves one bit every 16 ticks.

Transmitter transitions:
- IDLE→START when the queue holds a byte, the pause bit is clear, and CTS permits a start. The byte is popped at this point.
- START→DATA after 16 ticks.
- DATA→DATA between bits.
- DATA→STOP after the eighth bit.
- STOP→IDLE after 16 ticks.

Receiver transitions:
- IDLE→START on a tick that sees the line low.
- START→IDLE (rejection) when the line is high again at the 8th tick.
- START→DATA when the line is still low at the 8th tick.
- DATA→STOP after eight samples.
- STOP→IDLE at the stop-bit midpoint. The byte is stored only if the stop bit is high.

Top module: `uart_fc`

Register map (address : function):
- 0 : data. A write pushes a byte to the transmit queue. A read returns the head of the receive queue and pops it.
- 1 : control. Bits [1:0] are the threshold select, bit 2 enables auto-RTS, bit 3 enables auto-CTS and bit 4 pauses transmission.
- 2 : divisor, low byte.
- 3 : divisor, high byte.
- 4 : fraction. Bits [7:4] are the modulus M and bits [3:0] are the addend A.
- 5 : status. Bit 0 means the receive queue is not empty, bit 1 means the transmit queue is full, bit 2 means the transmitter is idle with an empty queue, and bits [7:3] hold the receive queue level.

## Requirements
- R1: After reset, txd_o is 1, rts_n_o is 0, irq_rx is 0, status reads 0x04, the divisor reads 1 and the fraction reads 0x10.
- R2: Each transmitted character is a low start bit, then eight data bits LSB first, then a high stop bit. Every bit lasts 16 baud ticks, and characters leave in the order they were written.
- R3: A received character sampled at bit midpoints with a high stop bit is stored, and reads of address 0 return received bytes in arrival order.
- R4: The transmit queue holds 16 bytes. Status bit 1 is set when it is full, and a write to a full queue is dropped.
- R5: irq_rx is 1 exactly when the receive level is at least the selected threshold. Select codes 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14.
- R6: With divisor D and fraction fields M and A, where A < M, each tick period is D or D+1 reference cycles, averaging D + A/M. For D=2, M=2, A=1 a bit lasts 40 cycles.
- R7: With auto-RTS enabled, rts_n_o is 1 while the receive level is at or above the threshold and returns to 0 once the level falls below it. With auto-RTS disabled, rts_n_o is 0.
- R8: With auto-CTS enabled and cts_n_i high, no new character starts.
- R9: A character already started is sent in full even if cts_n_i goes high partway through it.
- R10: While control bit 4 is set, no new character starts, and queued bytes remain queued.
- R11: A low pulse on rxd_i shorter than half a bit is rejected and stores nothing.
- R12: A pop by the register port in the same cycle as a store by the receiver loses no byte. The order is kept, and the level is unchanged by the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq_rx | output | 1 | Receive level at or above threshold |
| txd_o | output | 1 | Serial transmit line, idle high |
| rxd_i | input | 1 | Serial receive line |
| cts_n_i | input | 1 | Clear to send, active low |
| rts_n_o | output | 1 | Request to send, active low |

## Verification
The receive queue can be pushed by the receiver's stop-bit decision and popped by a host read in the same clock cycle. The bench provokes this collision by sweeping the read strobe across a window of cycle offsets around the predicted stop-bit midpoint of an incoming character, while one older byte is already queued, so that one offset lands on the store cycle. Every offset is judged the same way: the read must return the older byte, and afterwards the status level must read exactly one, with the new byte at the head.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    localparam int OSR    = 16;
    localparam int OSR_W  = $clog2(OSR);
    localparam int FRAC_W = 4;

    localparam logic [2:0] ADR_DATA   = 3'd0;
    localparam logic [2:0] ADR_CTRL   = 3'd1;
    localparam logic [2:0] ADR_DIV_LO = 3'd2;
    localparam logic [2:0] ADR_DIV_HI = 3'd3;
    localparam logic [2:0] ADR_FRAC   = 3'd4;
    localparam logic [2:0] ADR_STAT   = 3'd5;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    typedef struct packed {
        logic       pause;
        logic       cts_en;
        logic       rts_en;
        logic [1:0] trig_sel;
    } ctrl_t;

    function automatic logic [7:0] trig_level(input logic [1:0] sel);
        logic [7:0] lvl;
        unique case (sel)
            2'd0: lvl = 8'd1;
            2'd1: lvl = 8'd4;
            2'd2: lvl = 8'd8;
            default: lvl = 8'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_q];
    assign level   = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R4: occupancy never exceeds the depth
    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R4: a push into a full queue without a pop leaves the level unchanged
    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt_q == CW'(DEPTH)));

    // R12: simultaneous push and pop keep the level
    a_r12_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/uart_fc_baud.sv
module uart_fc_baud
    import uart_fc_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] mul,
    input  logic [FRAC_W-1:0] add,
    output logic              tick
);
    logic [DIV_W-1:0]  cnt_q;
    logic              stretch_q;
    logic [FRAC_W-1:0] acc_q;
    logic [DIV_W:0]    period;
    logic [FRAC_W:0]   sum;
    logic              frac_on;

    always_comb begin
        period  = ((div == '0) ? (DIV_W+1)'(1) : {1'b0, div}) + (DIV_W+1)'(stretch_q);
        tick    = ({1'b0, cnt_q} + (DIV_W+1)'(1)) >= period;
        frac_on = (mul != '0) && (add < mul);
        sum     = {1'b0, acc_q} + {1'b0, add};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            stretch_q <= 1'b0;
            acc_q     <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            if (!frac_on) begin
                acc_q     <= '0;
                stretch_q <= 1'b0;
            end else if (sum >= {1'b0, mul}) begin
                acc_q     <= FRAC_W'(sum - {1'b0, mul});
                stretch_q <= 1'b1;
            end else begin
                acc_q     <= sum[FRAC_W-1:0];
                stretch_q <= 1'b0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
    import uart_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       have_data,
    input  logic [7:0] data,
    input  logic       pause,
    input  logic       cts_en,
    input  logic       cts_ok,
    output logic       pop,
    output logic       busy,
    output logic       txd
);
    localparam logic [OSR_W-1:0] LAST = OSR_W'(OSR - 1);

    tx_state_t        state_q, state_d;
    logic [OSR_W-1:0] tcnt_q, tcnt_d;
    logic [2:0]       bit_q, bit_d;
    logic [7:0]       sh_q, sh_d;
    logic             go;

    assign go = have_data && !pause && (!cts_en || cts_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            tcnt_q  <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        unique case (state_q)
            TX_IDLE: begin
                if (go) begin
                    sh_d    = data;
                    tcnt_d  = '0;
                    state_d = TX_START;
                end
            end
            TX_START: begin
                if (tick) begin
                    if (tcnt_q == LAST) begin
                        tcnt_d  = '0;
                        bit_d   = '0;
                        state_d = TX_DATA;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            TX_DATA: begin
                if (tick) begin
                    if (tcnt_q == LAST) begin
                        tcnt_d = '0;
                        sh_d   = sh_q >> 1;
                        if (bit_q == 3'd7) state_d = TX_STOP;
                        else               bit_d   = bit_q + 1'b1;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            TX_STOP: begin
                if (tick) begin
                    if (tcnt_q == LAST) state_d = TX_IDLE;
                    else                tcnt_d  = tcnt_q + 1'b1;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        pop  = (state_q == TX_IDLE) && go;
        busy = (state_q != TX_IDLE);
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            default:  txd = 1'b1;
        endcase
    end

    // R8: with CTS gating on and CTS inactive, the idle transmitter stays idle
    a_r8_cts_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && cts_en && !cts_ok) |=> (state_q == TX_IDLE));

    // R9: a character in its data phase never falls back to idle
    a_r9_char_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA) |=> (state_q != TX_IDLE));

    // R10: pause keeps the idle transmitter idle
    a_r10_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && pause) |=> (state_q == TX_IDLE));

endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
    import uart_fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    output logic       push,
    output logic [7:0] data
);
    localparam logic [OSR_W-1:0] LAST = OSR_W'(OSR - 1);
    localparam logic [OSR_W-1:0] MID  = OSR_W'(OSR / 2 - 1);

    rx_state_t        state_q, state_d;
    logic [OSR_W-1:0] tcnt_q, tcnt_d;
    logic [2:0]       bit_q, bit_d;
    logic [7:0]       sh_q, sh_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            tcnt_q  <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        unique case (state_q)
            RX_IDLE: begin
                if (tick && !rxd) begin
                    tcnt_d  = '0;
                    state_d = RX_START;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (tcnt_q == MID) begin
                        tcnt_d = '0;
                        bit_d  = '0;
                        state_d = rxd ? RX_IDLE : RX_DATA;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (tcnt_q == LAST) begin
                        tcnt_d = '0;
                        sh_d   = {rxd, sh_q[7:1]};
                        if (bit_q == 3'd7) state_d = RX_STOP;
                        else               bit_d   = bit_q + 1'b1;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (tcnt_q == LAST) state_d = RX_IDLE;
                    else                tcnt_d  = tcnt_q + 1'b1;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        push = (state_q == RX_STOP) && tick && (tcnt_q == LAST) && rxd;
        data = sh_q;
    end

    // R11: a start bit that is high again at its midpoint returns to idle
    a_r11_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && tick && tcnt_q == MID && rxd) |=> (state_q == RX_IDLE));

    // R3: a byte is stored only on the stop-bit decision
    a_r3_store_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (state_q == RX_IDLE));

endmodule

// File: rtl/uart_fc.sv
module uart_fc
    import uart_fc_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 1,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_rx,
    output logic       txd_o,
    input  logic       rxd_i,
    input  logic       cts_n_i,
    output logic       rts_n_o
);
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] mul_q, add_q;
    logic [1:0]        rxd_sync, cts_sync;
    logic              tick;

    logic              tx_push, tx_pop, tx_full, tx_empty, tx_busy;
    logic [7:0]        tx_head;
    logic [CW-1:0]     tx_level;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]        rx_head, rx_byte;
    logic [CW-1:0]     rx_level;
    logic              at_trig;

    assign tx_push = reg_wr && (reg_addr == ADR_DATA);
    assign rx_pop  = reg_rd && (reg_addr == ADR_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            div_q    <= DIV_W'(DIV_RESET);
            mul_q    <= FRAC_W'(1);
            add_q    <= '0;
            rxd_sync <= 2'b11;
            cts_sync <= 2'b11;
        end else begin
            rxd_sync <= {rxd_sync[0], rxd_i};
            cts_sync <= {cts_sync[0], cts_n_i};
            if (reg_wr) begin
                unique case (reg_addr)
                    ADR_CTRL:   ctrl_q       <= ctrl_t'(reg_wdata[4:0]);
                    ADR_DIV_LO: div_q[7:0]   <= reg_wdata;
                    ADR_DIV_HI: div_q[DIV_W-1:8] <= reg_wdata[DIV_W-9:0];
                    ADR_FRAC: begin
                        mul_q <= reg_wdata[7:4];
                        add_q <= reg_wdata[3:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    uart_fc_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (div_q),
        .mul  (mul_q),
        .add  (add_q),
        .tick (tick)
    );

    uart_fc_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (tx_push),
        .din  (reg_wdata),
        .pop  (tx_pop),
        .head (tx_head),
        .level(tx_level),
        .full (tx_full),
        .empty(tx_empty)
    );

    uart_fc_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rx_push),
        .din  (rx_byte),
        .pop  (rx_pop),
        .head (rx_head),
        .level(rx_level),
        .full (rx_full),
        .empty(rx_empty)
    );

    uart_fc_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .have_data(!tx_empty),
        .data     (tx_head),
        .pause    (ctrl_q.pause),
        .cts_en   (ctrl_q.cts_en),
        .cts_ok   (!cts_sync[1]),
        .pop      (tx_pop),
        .busy     (tx_busy),
        .txd      (txd_o)
    );

    uart_fc_rx u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .rxd  (rxd_sync[1]),
        .push (rx_push),
        .data (rx_byte)
    );

    always_comb begin
        at_trig = rx_level >= CW'(trig_level(ctrl_q.trig_sel));
        irq_rx  = at_trig;
        rts_n_o = ctrl_q.rts_en && at_trig;
        unique case (reg_addr)
            ADR_DATA:   reg_rdata = rx_head;
            ADR_CTRL:   reg_rdata = {3'b000, ctrl_q};
            ADR_DIV_LO: reg_rdata = div_q[7:0];
            ADR_DIV_HI: reg_rdata = 8'(div_q[DIV_W-1:8]);
            ADR_FRAC:   reg_rdata = {mul_q, add_q};
            ADR_STAT:   reg_rdata = 8'({rx_level, tx_empty && !tx_busy, tx_full, !rx_empty});
            default:    reg_rdata = 8'h00;
        endcase
    end

    // R5: a full receive queue always meets any threshold
    a_r5_full_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> irq_rx);

    // R7: auto-RTS with a full receive queue holds RTS inactive
    a_r7_rts_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.rts_en && rx_full) |-> rts_n_o);

    // R7: RTS is only ever driven inactive when auto-RTS is on
    a_r7_rts_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n_o |-> ctrl_q.rts_en);

    // R4: the transmit queue is not drained while the transmitter is mid-character
    a_r4_no_pop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !tx_pop);

endmodule

// File: tb/uart_fc_bench.sv
module uart_fc_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_rx;
    logic       txd_o;
    logic       rxd_drv = 1'b1;
    logic       cts_n = 1'b0;
    logic       rts_n_o;

    int checks = 0;
    int fails = 0;
    int tx_seen = 0;
    int bit_cyc = 32;
    string cur_tag = "R2";
    bit finished = 1'b0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2 clk = ~clk;

    uart_fc u_uart_fc (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_rx   (irq_rx),
        .txd_o    (txd_o),
        .rxd_i    (rxd_drv),
        .cts_n_i  (cts_n),
        .rts_n_o  (rts_n_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx_send(input logic [7:0] b);
        txq.push_back(b);
        reg_write(3'd0, b);
    endtask

    task automatic rx_drive(input logic [7:0] b);
        rxq.push_back(b);
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (bit_cyc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_drv = b[i];
            repeat (bit_cyc) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (bit_cyc) @(negedge clk);
    endtask

    task automatic rx_read_check(input string tag);
        logic [7:0] d;
        logic [7:0] e;
        reg_read(3'd0, d);
        e = (rxq.size() > 0) ? rxq.pop_front() : 8'hxx;
        chk(d === e, tag, d, e);
    endtask

    task automatic stat_level(output int lvl);
        logic [7:0] s;
        reg_read(3'd5, s);
        lvl = int'(s[7:3]);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: decodes txd_o and compares against the expected queue
    initial begin : tx_monitor
        logic prev;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd_o) begin
                logic [7:0] b;
                logic [7:0] e;
                logic stop_ok;
                repeat (bit_cyc / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (bit_cyc) @(negedge clk);
                    b[i] = txd_o;
                end
                repeat (bit_cyc) @(negedge clk);
                stop_ok = txd_o;
                if (txq.size() == 0) begin
                    chk(1'b0, {cur_tag, " unexpected char"}, b, 0);
                end else begin
                    e = txq.pop_front();
                    chk((b == e) && stop_ok, cur_tag, {stop_ok, b}, {1'b1, e});
                end
                tx_seen++;
                prev = txd_o;
            end else begin
                prev = txd_o;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int lvl;
        int seen0;

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        chk(txd_o === 1'b1, "R1 txd", txd_o, 1);
        chk(rts_n_o === 1'b0, "R1 rts", rts_n_o, 0);
        chk(irq_rx === 1'b0, "R1 irq", irq_rx, 0);
        reg_read(3'd5, d); chk(d === 8'h04, "R1 status", d, 8'h04);
        reg_read(3'd2, d); chk(d === 8'h01, "R1 divisor", d, 8'h01);
        reg_read(3'd4, d); chk(d === 8'h10, "R1 fraction", d, 8'h10);

        reg_write(3'd2, 8'd2);
        reg_write(3'd3, 8'd0);

        // R2: framing and order
        cur_tag = "R2";
        tx_send(8'hA5); tx_send(8'h3C); tx_send(8'h01);
        wait_cyc(1300);
        chk(tx_seen == 3, "R2 count", tx_seen, 3);

        // R6: fractional divider, D=2 M=2 A=1 -> 40-cycle bits
        reg_write(3'd4, 8'h21);
        bit_cyc = 40;
        cur_tag = "R6";
        tx_send(8'h5A); tx_send(8'hC3);
        wait_cyc(1000);
        chk(tx_seen == 5, "R6 count", tx_seen, 5);
        rx_drive(8'h96);
        wait_cyc(20);
        rx_read_check("R6 rx");
        reg_write(3'd4, 8'h10);
        bit_cyc = 32;
        cur_tag = "R2";

        // R3: reception in order
        rx_drive(8'h81);
        rx_drive(8'h7E);
        wait_cyc(20);
        rx_read_check("R3 first");
        rx_read_check("R3 second");
        stat_level(lvl); chk(lvl == 0, "R3 drained", lvl, 0);

        // R5: thresholds
        reg_write(3'd1, 8'h01);
        for (int i = 0; i < 3; i++) rx_drive(8'(8'h10 + i));
        wait_cyc(20);
        chk(irq_rx === 1'b0, "R5 below 4", irq_rx, 0);
        rx_drive(8'h13);
        wait_cyc(20);
        chk(irq_rx === 1'b1, "R5 at 4", irq_rx, 1);
        reg_write(3'd1, 8'h03);
        wait_cyc(1);
        chk(irq_rx === 1'b0, "R5 sel3 is 14", irq_rx, 0);
        reg_write(3'd1, 8'h02);
        wait_cyc(1);
        chk(irq_rx === 1'b0, "R5 sel2 is 8", irq_rx, 0);
        reg_write(3'd1, 8'h00);
        wait_cyc(1);
        chk(irq_rx === 1'b1, "R5 sel0 is 1", irq_rx, 1);
        for (int i = 0; i < 4; i++) rx_read_check("R3 drain");
        chk(irq_rx === 1'b0, "R5 empty", irq_rx, 0);

        // R7: auto-RTS
        reg_write(3'd1, 8'h05);
        for (int i = 0; i < 3; i++) rx_drive(8'(8'h20 + i));
        wait_cyc(20);
        chk(rts_n_o === 1'b0, "R7 below", rts_n_o, 0);
        rx_drive(8'h23);
        wait_cyc(20);
        chk(rts_n_o === 1'b1, "R7 at trigger", rts_n_o, 1);
        rx_read_check("R7 pop");
        chk(rts_n_o === 1'b0, "R7 reassert", rts_n_o, 0);
        for (int i = 0; i < 3; i++) rx_read_check("R7 drain");
        reg_write(3'd1, 8'h01);
        for (int i = 0; i < 4; i++) rx_drive(8'(8'h30 + i));
        wait_cyc(20);
        chk(rts_n_o === 1'b0, "R7 disabled", rts_n_o, 0);
        for (int i = 0; i < 4; i++) rx_read_check("R7 drain2");
        reg_write(3'd1, 8'h00);

        // R11: short low pulse rejected
        @(negedge clk); rxd_drv = 1'b0;
        wait_cyc(12);
        rxd_drv = 1'b1;
        wait_cyc(400);
        stat_level(lvl); chk(lvl == 0, "R11 glitch", lvl, 0);
        rx_drive(8'h42);
        wait_cyc(20);
        rx_read_check("R11 after glitch");

        // R10 and R4: pause, fill to 16, drop the 17th
        reg_write(3'd1, 8'h10);
        seen0 = tx_seen;
        for (int i = 0; i < 16; i++) tx_send(8'(8'h60 + i));
        reg_read(3'd5, d); chk(d[1] === 1'b1, "R4 full flag", d[1], 1);
        reg_write(3'd0, 8'hEE);
        wait_cyc(600);
        chk(tx_seen == seen0, "R10 paused", tx_seen - seen0, 0);
        chk(txd_o === 1'b1, "R10 line idle", txd_o, 1);
        cur_tag = "R4";
        reg_write(3'd1, 8'h00);
        wait_cyc(16 * 330 + 600);
        chk(tx_seen == seen0 + 16, "R4 sixteen out", tx_seen - seen0, 16);
        reg_read(3'd5, d); chk(d[2] === 1'b1, "R4 idle after", d[2], 1);

        // R8: CTS blocks start
        cur_tag = "R8";
        reg_write(3'd1, 8'h08);
        @(negedge clk); cts_n = 1'b1;
        seen0 = tx_seen;
        tx_send(8'h11);
        wait_cyc(1000);
        chk(tx_seen == seen0, "R8 held", tx_seen - seen0, 0);
        chk(txd_o === 1'b1, "R8 line idle", txd_o, 1);
        @(negedge clk); cts_n = 1'b0;
        wait_cyc(500);
        chk(tx_seen == seen0 + 1, "R8 released", tx_seen - seen0, 1);

        // R9: CTS drop mid-character
        cur_tag = "R9";
        seen0 = tx_seen;
        tx_send(8'h22); tx_send(8'h33);
        wait_cyc(100);
        cts_n = 1'b1;
        wait_cyc(1500);
        chk(tx_seen == seen0 + 1, "R9 first completes", tx_seen - seen0, 1);
        @(negedge clk); cts_n = 1'b0;
        wait_cyc(500);
        chk(tx_seen == seen0 + 2, "R9 second after", tx_seen - seen0, 2);
        reg_write(3'd1, 8'h00);

        // R12: sweep a pop across the receiver's store cycle
        rx_drive(8'hE0);
        wait_cyc(10);
        for (int k = 290; k <= 325; k++) begin
            fork
                rx_drive(8'(k));
                begin
                    wait_cyc(k);
                    rx_read_check("R12 pop old");
                end
            join
            wait_cyc(10);
            stat_level(lvl);
            chk(lvl == 1, "R12 level", lvl, 1);
        end
        rx_read_check("R12 last");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule